// File: doc/BRIEF.md
# Timer Output Compare Unit

This block watches a 16-bit free-running count that arrives from outside and holds five compare channels against it. Each channel keeps its own 16-bit compare value and a two-bit action code. When the count reaches a channel's compare value, or when software strobes that channel's force bit, the channel's output pin is left alone, inverted, driven low or driven high according to its action code. A match also raises a sticky flag, and an interrupt line is asserted while any flag is raised whose enable bit is also set.

Channel 0 is the master channel. Besides its own pin action, every event on channel 0 drives each pin selected in a 5-bit master mask to the matching bit of a 5-bit master data value. This lets one compare event place several pins at chosen levels in the same clock. Software reaches all state through a simple register bus with single-cycle writes and a combinational read path. Flags clear only when a 1 is written to their position. Periodic outputs are made by advancing a compare value by a fixed step after each event: at a 2 MHz count, a step of 2000 gives 1 ms.

Top module: `ocu_top`

## Requirements
- R1: After reset every pin is 0, the interrupt line is 0, and all compare values, action codes, enables, flags, master mask and master data read as 0.
- R2: A match event on channel i happens in the clock where `countIn` equals compare register i (address i, i = 0..4) and differs from its value in the previous clock. A count held at the same value gives only one event.
- R3: The action code of channel i is bits [2i+1:2i] of the action register (address 5). On an event, 00 leaves the pin unchanged, 01 inverts it, 10 drives it to 0 and 11 drives it to 1. The new pin level is visible right after the clock edge of the event.
- R4: A match event on channel i sets flag bit i (flag register, address 7). This happens whatever the action code is, including 00.
- R5: Writing the flag register clears exactly the flags whose data bit is 1. Bits written as 0 are unchanged, and a match in the same clock wins over the clear.
- R6: `irqOut` is 1 exactly while some flag bit i and enable bit i (enable register, address 6) are both 1.
- R7: Writing address 8 raises a forced event on each channel whose data bit is 1. This applies the action code to the pin but does not set the flag. Address 8 always reads as 0.
- R8: On any channel 0 event (match or forced), each pin j with bit j set in the master mask (address 9) takes bit j of master data (address 10). Pins outside the mask are left to their own channels.
- R9: When a master-mask drive and a channel's own action hit the same pin in the same clock, the master data value wins.
- R10: Address 11 reads back the current pin levels in bits [4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| countIn | input | 16 | External free-running count |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for reads and writes |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for `regAddr` (combinational) |
| cmpPins | output | 5 | Compare output pins, bit i belongs to channel i |
| irqOut | output | 1 | Interrupt request |

## Verification
A wrong match detector or a wrong action decode shows on `cmpPins` in the first clock after the count reaches the compare value. An event that is repeated or lost shows on a held count, or on a return to the same value. Flag or enable corruption shows on `irqOut` and on the flag readback right after the edge that caused it. A lost master-priority rule appears as a pin at the wrong level in that same clock, because both drivers act at one edge.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  localparam int OCU_CHANNELS = 5;
  localparam int OCU_CNT_W    = 16;
  localparam int OCU_ADDR_W   = 4;
  localparam int OCU_ACT_W    = 2;

  localparam logic [OCU_ADDR_W-1:0] ADDR_ACTION = 4'd5;
  localparam logic [OCU_ADDR_W-1:0] ADDR_ENABLE = 4'd6;
  localparam logic [OCU_ADDR_W-1:0] ADDR_FLAGS  = 4'd7;
  localparam logic [OCU_ADDR_W-1:0] ADDR_FORCE  = 4'd8;
  localparam logic [OCU_ADDR_W-1:0] ADDR_MMASK  = 4'd9;
  localparam logic [OCU_ADDR_W-1:0] ADDR_MDATA  = 4'd10;
  localparam logic [OCU_ADDR_W-1:0] ADDR_PINS   = 4'd11;

  typedef enum logic [OCU_ACT_W-1:0] {
    ACT_KEEP   = 2'b00,
    ACT_INVERT = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } pinAction_e;

  typedef struct packed {
    logic [OCU_CHANNELS-1:0] cmpWr;
    logic                    actWr;
    logic                    enWr;
    logic                    flagClr;
    logic                    forceWr;
    logic                    maskWr;
    logic                    dataWr;
    logic [OCU_CNT_W-1:0]    wdata;
  } ocuStrobe_t;

  function automatic logic applyAction(input pinAction_e act, input logic cur);
    case (act)
      ACT_INVERT: applyAction = ~cur;
      ACT_LOW:    applyAction = 1'b0;
      ACT_HIGH:   applyAction = 1'b1;
      default:    applyAction = cur;
    endcase
  endfunction
endpackage

// File: rtl/ocu_ctrl.sv
module ocu_ctrl
  import ocu_pkg::*;
(
  input  logic                  regWr,
  input  logic [OCU_ADDR_W-1:0] regAddr,
  input  logic [OCU_CNT_W-1:0]  regWdata,
  output ocuStrobe_t            strobe
);
  always_comb begin
    strobe         = '0;
    strobe.wdata   = regWdata;
    for (int i = 0; i < OCU_CHANNELS; i++) begin
      strobe.cmpWr[i] = regWr && (regAddr == OCU_ADDR_W'(i));
    end
    strobe.actWr   = regWr && (regAddr == ADDR_ACTION);
    strobe.enWr    = regWr && (regAddr == ADDR_ENABLE);
    strobe.flagClr = regWr && (regAddr == ADDR_FLAGS);
    strobe.forceWr = regWr && (regAddr == ADDR_FORCE);
    strobe.maskWr  = regWr && (regAddr == ADDR_MMASK);
    strobe.dataWr  = regWr && (regAddr == ADDR_MDATA);
  end
endmodule

// File: rtl/ocu_datapath.sv
module ocu_datapath
  import ocu_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [OCU_CNT_W-1:0]    countIn,
  input  ocuStrobe_t              strobe,
  input  logic [OCU_ADDR_W-1:0]   regAddr,
  output logic [OCU_CNT_W-1:0]    regRdata,
  output logic [OCU_CHANNELS-1:0] pinReg,
  output logic [OCU_CHANNELS-1:0] flagReg,
  output logic [OCU_CHANNELS-1:0] enReg,
  output logic [OCU_CHANNELS-1:0] masterMask,
  output logic [OCU_CHANNELS-1:0] masterData,
  output logic [OCU_CHANNELS-1:0] matchEvt,
  output logic                    masterEvt,
  output logic                    irq
);
  localparam int ACT_BITS = OCU_CHANNELS * OCU_ACT_W;

  logic [OCU_CNT_W-1:0]    cmpReg [OCU_CHANNELS];
  logic [ACT_BITS-1:0]     actReg;
  logic [OCU_CNT_W-1:0]    prevCount;
  logic                    countMoved;
  logic [OCU_CHANNELS-1:0] forceVec;
  logic [OCU_CHANNELS-1:0] pinNext;
  logic [OCU_CHANNELS-1:0] clrVec;

  assign countMoved = (countIn != prevCount);
  assign forceVec   = strobe.forceWr ? strobe.wdata[OCU_CHANNELS-1:0] : '0;
  assign clrVec     = strobe.flagClr ? strobe.wdata[OCU_CHANNELS-1:0] : '0;
  assign masterEvt  = matchEvt[0] | forceVec[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevCount <= '0;
    else       prevCount <= countIn;
  end

  generate
    for (genvar g = 0; g < OCU_CHANNELS; g++) begin : gChan
      pinAction_e chanAct;
      logic       ownEvt;
      logic       ownLevel;

      assign chanAct     = pinAction_e'(actReg[g*OCU_ACT_W +: OCU_ACT_W]);
      assign matchEvt[g] = countMoved && (countIn == cmpReg[g]);
      assign ownEvt      = matchEvt[g] | forceVec[g];
      assign ownLevel    = ownEvt ? applyAction(chanAct, pinReg[g]) : pinReg[g];
      assign pinNext[g]  = (masterEvt && masterMask[g]) ? masterData[g] : ownLevel;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                cmpReg[g] <= '0;
        else if (strobe.cmpWr[g]) cmpReg[g] <= strobe.wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actReg     <= '0;
      enReg      <= '0;
      flagReg    <= '0;
      masterMask <= '0;
      masterData <= '0;
      pinReg     <= '0;
    end else begin
      if (strobe.actWr)  actReg     <= strobe.wdata[ACT_BITS-1:0];
      if (strobe.enWr)   enReg      <= strobe.wdata[OCU_CHANNELS-1:0];
      if (strobe.maskWr) masterMask <= strobe.wdata[OCU_CHANNELS-1:0];
      if (strobe.dataWr) masterData <= strobe.wdata[OCU_CHANNELS-1:0];
      flagReg <= (flagReg & ~clrVec) | matchEvt;
      pinReg  <= pinNext;
    end
  end

  assign irq = |(flagReg & enReg);

  always_comb begin
    regRdata = '0;
    if (regAddr < OCU_ADDR_W'(OCU_CHANNELS)) begin
      for (int i = 0; i < OCU_CHANNELS; i++) begin
        if (regAddr == OCU_ADDR_W'(i)) regRdata = cmpReg[i];
      end
    end else begin
      case (regAddr)
        ADDR_ACTION: regRdata[ACT_BITS-1:0]     = actReg;
        ADDR_ENABLE: regRdata[OCU_CHANNELS-1:0] = enReg;
        ADDR_FLAGS:  regRdata[OCU_CHANNELS-1:0] = flagReg;
        ADDR_MMASK:  regRdata[OCU_CHANNELS-1:0] = masterMask;
        ADDR_MDATA:  regRdata[OCU_CHANNELS-1:0] = masterData;
        ADDR_PINS:   regRdata[OCU_CHANNELS-1:0] = pinReg;
        default:     regRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ocu_top.sv
module ocu_top
  import ocu_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [OCU_CNT_W-1:0]    countIn,
  input  logic                    regWr,
  input  logic [OCU_ADDR_W-1:0]   regAddr,
  input  logic [OCU_CNT_W-1:0]    regWdata,
  output logic [OCU_CNT_W-1:0]    regRdata,
  output logic [OCU_CHANNELS-1:0] cmpPins,
  output logic                    irqOut
);
  ocuStrobe_t              strobe;
  logic [OCU_CHANNELS-1:0] flagReg;
  logic [OCU_CHANNELS-1:0] enReg;
  logic [OCU_CHANNELS-1:0] masterMask;
  logic [OCU_CHANNELS-1:0] masterData;
  logic [OCU_CHANNELS-1:0] matchEvt;
  logic                    masterEvt;

  ocu_ctrl u_ctrl (
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .strobe   (strobe)
  );

  ocu_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .countIn    (countIn),
    .strobe     (strobe),
    .regAddr    (regAddr),
    .regRdata   (regRdata),
    .pinReg     (cmpPins),
    .flagReg    (flagReg),
    .enReg      (enReg),
    .masterMask (masterMask),
    .masterData (masterData),
    .matchEvt   (matchEvt),
    .masterEvt  (masterEvt),
    .irq        (irqOut)
  );
endmodule

// File: rtl/ocu_checker.sv
module ocu_checker
  import ocu_pkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic [OCU_CNT_W-1:0]    countIn,
  input logic                    regWr,
  input logic [OCU_ADDR_W-1:0]   regAddr,
  input logic [OCU_CHANNELS-1:0] cmpPins,
  input logic                    irqOut,
  input logic [OCU_CHANNELS-1:0] flagReg,
  input logic [OCU_CHANNELS-1:0] enReg,
  input logic [OCU_CHANNELS-1:0] masterMask,
  input logic [OCU_CHANNELS-1:0] masterData,
  input logic [OCU_CHANNELS-1:0] matchEvt,
  input logic                    masterEvt
);
  // R2: a held count with no bus write cannot move any pin
  assert_held_count_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(countIn) && !regWr) |=> $stable(cmpPins));

  // R4: each match leaves its flag set after the edge
  assert_match_sets_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|matchEvt) |=> (($past(matchEvt) & ~flagReg) == '0));

  // R5: without a write to the flag register no flag drops
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regAddr == ADDR_FLAGS) |=> (($past(flagReg) & ~flagReg) == '0));

  // R6: an interrupt needs at least one enable bit
  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (enReg != '0));

  // R8 / R9: masked pins follow master data after a channel 0 event
  assert_master_drive_R9: assert property (@(posedge clk) disable iff (!rstN)
    masterEvt |=> (((cmpPins ^ $past(masterData)) & $past(masterMask)) == '0));
endmodule

bind ocu_top ocu_checker u_ocu_checker (
  .clk        (clk),
  .rstN       (rstN),
  .countIn    (countIn),
  .regWr      (regWr),
  .regAddr    (regAddr),
  .cmpPins    (cmpPins),
  .irqOut     (irqOut),
  .flagReg    (flagReg),
  .enReg      (enReg),
  .masterMask (masterMask),
  .masterData (masterData),
  .matchEvt   (matchEvt),
  .masterEvt  (masterEvt)
);

// File: tb/ocu_top_bench.sv
module ocu_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] countIn = 16'h7000;
  logic        regWr = 1'b0;
  logic [3:0]  regAddr = 4'd0;
  logic [15:0] regWdata = 16'd0;
  logic [15:0] regRdata;
  logic [4:0]  cmpPins;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ocu_top u_ocu_top (
    .clk(clk), .rstN(rstN), .countIn(countIn), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .cmpPins(cmpPins), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic stepCount(input logic [15:0] v);
    @(negedge clk);
    countIn = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chkPins(input string tag, input logic [4:0] exp);
    @(negedge clk);
    check(tag, {11'd0, cmpPins}, {11'd0, exp});
  endtask

  task automatic chkReg(input string tag, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] d;
    regRead(a, d);
    check(tag, d, exp);
  endtask

  task automatic t_reset;
    chkPins("R1 pins", 5'b00000);
    check("R1 irq", {15'd0, irqOut}, 16'd0);
    chkReg("R1 flags", 4'd7, 16'd0);
    chkReg("R1 cmp0", 4'd0, 16'd0);
    chkReg("R1 action", 4'd5, 16'd0);
    chkReg("R1 mask", 4'd9, 16'd0);
    for (int i = 0; i < 5; i++) regWrite(4'(i), 16'h0100 * 16'(i + 1));
    chkReg("R1 cmp3 written", 4'd3, 16'h0400);
  endtask

  task automatic t_toggle;
    regWrite(4'd5, 16'h0010);                 // ch2 invert
    stepCount(16'h0300);
    chkPins("R3 toggle up", 5'b00100);
    chkReg("R4 flag2", 4'd7, 16'h0004);
    stepCount(16'h0300);                      // held count
    chkPins("R2 held count one event", 5'b00100);
    stepCount(16'h7001);
    stepCount(16'h0300);
    chkPins("R2 return rematch", 5'b00000);
    chkReg("R10 pin readback", 4'd11, 16'h0000);
  endtask

  task automatic t_setclr;
    regWrite(4'd5, 16'h03C0);                 // ch3 high, ch4 high
    stepCount(16'h0400);
    chkPins("R3 set ch3", 5'b01000);
    stepCount(16'h0500);
    chkPins("R3 set ch4", 5'b11000);
    regWrite(4'd5, 16'h02C0);                 // ch3 high, ch4 low
    stepCount(16'h7002);
    stepCount(16'h0500);
    chkPins("R3 clear ch4", 5'b01000);
    chkReg("R10 pin readback", 4'd11, 16'h0008);
    chkReg("R4 flags 2..4", 4'd7, 16'h001C);
  endtask

  task automatic t_none;
    regWrite(4'd5, 16'h0000);
    stepCount(16'h0200);
    chkPins("R3 keep action", 5'b01000);
    chkReg("R4 flag with keep", 4'd7, 16'h001E);
  endtask

  task automatic t_flags;
    regWrite(4'd7, 16'h0000);
    chkReg("R5 write zero", 4'd7, 16'h001E);
    regWrite(4'd7, 16'h0004);
    chkReg("R5 clear one", 4'd7, 16'h001A);
    regWrite(4'd7, 16'h001F);
    chkReg("R5 clear all", 4'd7, 16'h0000);
  endtask

  task automatic t_irq;
    stepCount(16'h7003);
    stepCount(16'h0200);                      // flag1
    check("R6 no enable", {15'd0, irqOut}, 16'd0);
    regWrite(4'd6, 16'h0002);
    check("R6 enabled", {15'd0, irqOut}, 16'd1);
    regWrite(4'd6, 16'h0001);
    check("R6 other enable", {15'd0, irqOut}, 16'd0);
    regWrite(4'd6, 16'h0002);
    regWrite(4'd7, 16'h0002);
    check("R6 flag cleared", {15'd0, irqOut}, 16'd0);
    regWrite(4'd6, 16'h0000);
  endtask

  task automatic t_force;
    regWrite(4'd5, 16'h0010);                 // ch2 invert
    regWrite(4'd8, 16'h0004);
    chkPins("R7 forced toggle", 5'b01100);
    chkReg("R7 no flag", 4'd7, 16'h0000);
    chkReg("R7 reads zero", 4'd8, 16'h0000);
  endtask

  task automatic t_master;
    regWrite(4'd5, 16'h0001);                 // ch0 invert only
    regWrite(4'd9, 16'h001A);
    regWrite(4'd10, 16'h000A);
    stepCount(16'h0100);
    chkPins("R8 master drive", 5'b01111);
    chkReg("R4 flag0", 4'd7, 16'h0001);
  endtask

  task automatic t_priority;
    regWrite(4'd2, 16'h0100);
    regWrite(4'd5, 16'h0030);                 // ch2 high, ch0 keep
    regWrite(4'd9, 16'h0004);
    regWrite(4'd10, 16'h0000);
    stepCount(16'h7004);
    stepCount(16'h0100);
    chkPins("R9 master wins", 5'b01011);
    chkReg("R4 flags 0 and 2", 4'd7, 16'h0005);
    regWrite(4'd9, 16'h0010);
    regWrite(4'd10, 16'h0010);
    regWrite(4'd8, 16'h0001);                 // forced ch0 event
    chkPins("R8 forced master", 5'b11011);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_toggle();
    t_setclr();
    t_none();
    t_flags();
    t_irq();
    t_force();
    t_master();
    t_priority();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule